// File: doc/BRIEF.md
# Packed Chroma-Key Pixel Overlay

This block composites two pixel streams one word at a time. Each word holds eight 8-bit pixel values. Any foreground pixel that matches a programmable key colour is replaced by the background pixel in the same position. Every other foreground pixel passes through unchanged. All lanes are decided together. A lane-wise equality compare against the key, copied into every lane, gives a packed selection. That selection keeps the wanted background bytes, clears the keyed foreground bytes, and the two filtered words are joined with a bitwise OR.

Words enter and leave through valid/ready handshakes, and a two-stage pipeline sits between them. The first stage registers the compare result together with both input words. The second stage registers the merged word. The key is held in a register that software-side logic loads with a one-cycle strobe. A one-bit-per-lane summary of the selection travels out with each result.

Top module: `ckey_overlay`

## Requirements
- R1: For each accepted word, `out_mask` bit i is 1 exactly when foreground lane i (bits 8i+7..8i of `fg_in`) equals the key register, and 0 otherwise.
- R2: Output lane i (bits 8i+7..8i of `out_pix`) equals background lane i when mask bit i is 1, and foreground lane i when it is 0.
- R3: A cycle with `key_load` high writes `key_in` into the key register at that clock edge. A word accepted in the same cycle is still compared against the previous key, and words accepted later use the new key.
- R4: A word accepted at clock edge N is presented with `out_valid` high after edge N+1, provided `out_ready` was high in the cycle before edge N+1.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_pix` and `out_mask` hold their values into the next cycle.
- R6: `in_ready` is high whenever `out_ready` is high, so the block accepts one word per cycle. `in_ready` goes low only when both stages hold words and `out_ready` is low.
- R7: Every accepted word leaves exactly once, in acceptance order.
- R8: During and straight after reset, `out_valid` is 0 and `in_ready` is 1, and the key register holds 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_load | input | 1 | Strobe that writes `key_in` into the key register |
| key_in | input | 8 | New key colour value |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts an input word this cycle |
| fg_in | input | 64 | Foreground word, eight packed pixels |
| bg_in | input | 64 | Background word, eight packed pixels |
| out_valid | output | 1 | Composited word present |
| out_ready | input | 1 | Downstream accepts the output word |
| out_pix | output | 64 | Composited word |
| out_mask | output | 8 | One bit per lane, set where the background was taken |

## Verification
Two situations are hard to reach. The first is a key change landing in the same cycle as a word handshake, because the compare must use the old key while the register takes the new one. The stimulus creates it directly: it sends a word whose lanes hold the old key in odd lanes and the new key in even lanes, with the load strobe high in that cycle. It then sends the same word again after the load, so the two masks must come out as complements. The second is a full pipeline with both stages holding words and the sink stalled. A directed phase fills both stages against a stalled sink and then checks that input is refused. A long random phase follows, mixing random sink stalls, random input gaps and stray key loads, with a per-lane reference model scoring every output word.

// File: rtl/ckey_pkg.sv
package ckey_pkg;
    localparam int unsigned CK_LANES  = 8;
    localparam int unsigned CK_LANE_W = 8;
endpackage

// File: rtl/ckey_lane_cmp.sv
module ckey_lane_cmp #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] fg,
    input  logic [LANE_W-1:0]       key,
    output logic [LANES-1:0]        hit
);
    localparam int unsigned W = LANES * LANE_W;

    logic [W-1:0] key_rep;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // replicate the key byte into every lane, then compare lane-wise
        assign key_rep[i*LANE_W +: LANE_W] = key;
        assign hit[i] = (fg[i*LANE_W +: LANE_W] == key_rep[i*LANE_W +: LANE_W]);
    end
endmodule

// File: rtl/ckey_mask_expand.sv
module ckey_mask_expand #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned LANE_W = 8
) (
    input  logic [LANES-1:0]        bits,
    output logic [LANES*LANE_W-1:0] wide
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign wide[i*LANE_W +: LANE_W] = {LANE_W{bits[i]}};
    end
endmodule

// File: rtl/ckey_merge.sv
module ckey_merge #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] fg,
    input  logic [W-1:0] bg,
    input  logic [W-1:0] sel,
    output logic [W-1:0] pix
);
    logic [W-1:0] bg_keep;
    logic [W-1:0] fg_keep;

    assign bg_keep = bg & sel;
    assign fg_keep = fg & ~sel;
    assign pix     = bg_keep | fg_keep;
endmodule

// File: rtl/ckey_overlay.sv
module ckey_overlay
    import ckey_pkg::*;
#(
    parameter int unsigned       LANES    = CK_LANES,
    parameter int unsigned       LANE_W   = CK_LANE_W,
    parameter logic [LANE_W-1:0] KEY_INIT = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    key_load,
    input  logic [LANE_W-1:0]       key_in,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*LANE_W-1:0] fg_in,
    input  logic [LANES*LANE_W-1:0] bg_in,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LANES*LANE_W-1:0] out_pix,
    output logic [LANES-1:0]        out_mask
);
    localparam int unsigned W = LANES * LANE_W;

    typedef struct packed {
        logic [LANE_W-1:0] key;
        logic              s1_v;
        logic [W-1:0]      s1_fg;
        logic [W-1:0]      s1_bg;
        logic [LANES-1:0]  s1_m;
        logic              s2_v;
        logic [W-1:0]      s2_pix;
        logic [LANES-1:0]  s2_m;
    } state_t;

    state_t q, d;

    logic [LANE_W-1:0] key_cur;
    logic [LANES-1:0]  hit;
    logic [W-1:0]      sel_wide;
    logic [W-1:0]      merged;
    logic              s2_take;
    logic              s1_take;

    assign key_cur = q.key;

    ckey_lane_cmp #(.LANES(LANES), .LANE_W(LANE_W)) u_cmp (
        .fg  (fg_in),
        .key (key_cur),
        .hit (hit)
    );

    ckey_mask_expand #(.LANES(LANES), .LANE_W(LANE_W)) u_expand (
        .bits (q.s1_m),
        .wide (sel_wide)
    );

    ckey_merge #(.W(W)) u_merge (
        .fg  (q.s1_fg),
        .bg  (q.s1_bg),
        .sel (sel_wide),
        .pix (merged)
    );

    always_comb begin
        d       = q;
        s2_take = !q.s2_v || out_ready;
        s1_take = !q.s1_v || s2_take;

        if (key_load) begin
            d.key = key_in;
        end

        if (s2_take) begin
            d.s2_v = q.s1_v;
            if (q.s1_v) begin
                d.s2_pix = merged;
                d.s2_m   = q.s1_m;
            end
        end

        if (s1_take) begin
            d.s1_v = in_valid;
            if (in_valid) begin
                d.s1_fg = fg_in;
                d.s1_bg = bg_in;
                d.s1_m  = hit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.key <= KEY_INIT;
        end else begin
            q <= d;
        end
    end

    assign in_ready  = s1_take;
    assign out_valid = q.s2_v;
    assign out_pix   = q.s2_pix;
    assign out_mask  = q.s2_m;
endmodule

// File: rtl/ckey_overlay_chk.sv
module ckey_overlay_chk #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned LANE_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    key_load,
    input logic [LANE_W-1:0]       key_in,
    input logic [LANE_W-1:0]       key_cur,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [LANES*LANE_W-1:0] out_pix,
    input logic [LANES-1:0]        out_mask
);
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_mask)); // R5

    AST_READY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid && !out_ready); // R6

    AST_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) ##1 out_ready |=> out_valid); // R4

    AST_KEY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        key_load |=> key_cur == $past(key_in)); // R3

    AST_KEY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !key_load |=> $stable(key_cur)); // R3

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid && in_ready); // R8
endmodule

bind ckey_overlay ckey_overlay_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_load  (key_load),
    .key_in    (key_in),
    .key_cur   (key_cur),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pix   (out_pix),
    .out_mask  (out_mask)
);

// File: tb/ckey_overlay_bench.sv
module ckey_overlay_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_load = 1'b0;
    logic [7:0]  key_in = 8'h00;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] fg_in = '0;
    logic [63:0] bg_in = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_pix;
    logic [7:0]  out_mask;

    always #4 clk = ~clk;

    ckey_overlay u_ckey_overlay (
        .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
        .in_valid(in_valid), .in_ready(in_ready), .fg_in(fg_in), .bg_in(bg_in),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
        .out_mask(out_mask)
    );

    int n_tests = 0;
    int n_fail = 0;
    int n_acc = 0;
    int n_out = 0;
    bit finished = 1'b0;
    bit acc_last = 1'b0;
    logic [7:0] key_m = 8'h00;
    logic [63:0] q_pix[$];
    logic [7:0]  q_mask[$];
    string       q_tag[$];
    string       cur_tag = "";
    bit          hold_p = 1'b0;
    logic [63:0] hold_pix;
    logic [7:0]  hold_mask;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_mask(input logic [63:0] fg, input logic [7:0] k);
        logic [7:0] m;
        for (int i = 0; i < 8; i++) m[i] = (fg[i*8 +: 8] == k);
        return m;
    endfunction

    function automatic logic [63:0] ref_pix(input logic [63:0] fg, input logic [63:0] bg,
                                            input logic [7:0] k);
        logic [63:0] p;
        for (int i = 0; i < 8; i++)
            p[i*8 +: 8] = (fg[i*8 +: 8] == k) ? bg[i*8 +: 8] : fg[i*8 +: 8];
        return p;
    endfunction

    function automatic logic [63:0] gen_fg(input logic [7:0] k, input int dens);
        logic [63:0] w;
        for (int i = 0; i < 8; i++)
            w[i*8 +: 8] = (($urandom % 100) < dens) ? k : 8'($urandom);
        return w;
    endfunction

    // reference model and scoreboard, sampled mid-cycle
    always @(negedge clk) begin
        #2;
        if (!rst_n) begin
            key_m = 8'h00;
            hold_p = 1'b0;
            acc_last = 1'b0;
            q_pix.delete();
            q_mask.delete();
            q_tag.delete();
        end else begin
            if (hold_p) begin
                check(out_valid == 1'b1, "R5", "valid dropped during stall", 64'(out_valid), 64'd1);
                check(out_pix == hold_pix, "R5", "pixels moved during stall", out_pix, hold_pix);
                check(out_mask == hold_mask, "R5", "mask moved during stall", 64'(out_mask), 64'(hold_mask));
            end
            if (out_ready)
                check(in_ready == 1'b1, "R6", "in_ready with sink ready", 64'(in_ready), 64'd1);
            acc_last = in_valid && in_ready;
            if (acc_last) begin
                q_pix.push_back(ref_pix(fg_in, bg_in, key_m));
                q_mask.push_back(ref_mask(fg_in, key_m));
                q_tag.push_back(cur_tag);
                n_acc++;
            end
            if (key_load) key_m = key_in;
            if (out_valid && out_ready) begin
                n_out++;
                if (q_pix.size() == 0) begin
                    check(1'b0, "R7", "word with nothing pending", out_pix, 64'd0);
                end else begin
                    logic [63:0] ep;
                    logic [7:0]  em;
                    string       tg;
                    ep = q_pix.pop_front();
                    em = q_mask.pop_front();
                    tg = q_tag.pop_front();
                    check(out_mask == em, {"R1 ", tg}, "lane mask", 64'(out_mask), 64'(em));
                    check(out_pix == ep, {"R2 ", tg}, "merged pixels", out_pix, ep);
                end
            end
            hold_p = out_valid && !out_ready;
            hold_pix = out_pix;
            hold_mask = out_mask;
        end
    end

    task automatic send(input logic [63:0] fg, input logic [63:0] bg,
                        input bit kl, input logic [7:0] kv);
        @(negedge clk);
        in_valid = 1'b1;
        fg_in = fg;
        bg_in = bg;
        key_load = kl;
        key_in = kv;
        #3;
        while (!acc_last) begin
            @(negedge clk);
            key_load = 1'b0;
            #3;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            key_load = 1'b0;
        end
    endtask

    task automatic load_key(input logic [7:0] k);
        @(negedge clk);
        in_valid = 1'b0;
        key_load = 1'b1;
        key_in = k;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #3;
        check(!out_valid, "R8", "out_valid in reset", 64'(out_valid), 64'd0);
        check(in_ready, "R8", "in_ready in reset", 64'(in_ready), 64'd1);
        @(negedge clk);
        rst_n = 1'b1;
        out_ready = 1'b1;
        #3;
        check(!out_valid, "R8", "out_valid after reset", 64'(out_valid), 64'd0);

        // key register comes out of reset as 0x00
        cur_tag = "R8";
        send(64'h00_11_00_22_00_33_00_44, 64'hA1A2A3A4A5A6A7A8, 1'b0, 8'h00);
        idle(4);

        // two-stage latency with an idle pipeline and a ready sink
        cur_tag = "R4";
        send(64'h0102030405060708, 64'hFFFFFFFFFFFFFFFF, 1'b0, 8'h00);
        @(negedge clk);
        in_valid = 1'b0;
        #3;
        check(!out_valid, "R4", "valid one edge after accept", 64'(out_valid), 64'd0);
        @(negedge clk);
        #3;
        check(out_valid, "R4", "valid two edges after accept", 64'(out_valid), 64'd1);
        idle(3);

        // fixed patterns
        cur_tag = "";
        load_key(8'h2A);
        send({8{8'h2A}}, 64'h1122334455667788, 1'b0, 8'h00);
        send(64'h0011223344556677, 64'h8899AABBCCDDEEFF, 1'b0, 8'h00);
        send(64'h2A_00_2A_00_2A_00_2A_00, 64'hCAFEF00DDEADBEEF, 1'b0, 8'h00);
        send(64'h00_2A_2A_00_00_2A_2A_00, 64'h0F0F0F0F0F0F0F0F, 1'b0, 8'h00);

        // key load in the same cycle as an accepted word
        cur_tag = "R3";
        send(64'h2A_5C_2A_5C_2A_5C_2A_5C, 64'h9988776655443322, 1'b1, 8'h5C);
        send(64'h2A_5C_2A_5C_2A_5C_2A_5C, 64'h9988776655443322, 1'b0, 8'h00);
        cur_tag = "";
        for (int i = 0; i < 20; i++)
            send(gen_fg(8'h5C, 50), {$urandom, $urandom}, 1'b0, 8'h00);
        idle(4);

        // full pipeline against a stalled sink
        @(negedge clk);
        out_ready = 1'b0;
        send(gen_fg(8'h5C, 40), {$urandom, $urandom}, 1'b0, 8'h00);
        send(gen_fg(8'h5C, 40), {$urandom, $urandom}, 1'b0, 8'h00);
        @(negedge clk);
        in_valid = 1'b1;
        fg_in = gen_fg(8'h5C, 40);
        #3;
        check(!in_ready, "R6", "in_ready with both stages full", 64'(in_ready), 64'd0);
        repeat (3) @(negedge clk);
        out_ready = 1'b1;
        idle(6);

        // random traffic, stalls and key loads
        for (int c = 0; c < 1500; c++) begin
            @(negedge clk);
            out_ready = (($urandom % 4) != 0);
            if (!(in_valid && !acc_last)) begin
                in_valid = (($urandom % 3) != 0);
                fg_in = gen_fg(key_m, 45);
                bg_in = {$urandom, $urandom};
            end
            key_load = (($urandom % 16) == 0);
            key_in = 8'($urandom % 4) + 8'h40;
        end
        @(negedge clk);
        in_valid = 1'b0;
        key_load = 1'b0;
        out_ready = 1'b1;
        idle(10);
        #3;
        check(q_pix.size() == 0, "R7", "words left undelivered", 64'(q_pix.size()), 64'd0);
        check(n_acc == n_out, "R7", "accepted vs delivered", 64'(n_out), 64'(n_acc));
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule